// File: doc/BRIEF.md
# Key-Protected Register Write Gate

This block sits on a simple write-only register bus (address, write data, write strobe) and guards a set of sensitive control registers. A protected register takes a new value only through a strict three-write sequence. First, the register's own first key value goes to its first-key address. Next, the new value goes to the protected address. Last, the register's own second key value goes to its second-key address. The value written in the middle step waits in a shadow latch. It moves into the committed register only when the closing key is correct.

Each protected register has its own sequence tracker and its own pair of key addresses and key values, so keys for one register never unlock another. Any bus write that is not the expected next step returns the tracker to idle and discards the shadow value. The one exception is a correct first-key write, which arms the tracker again. Cycles with the write strobe low do not move any tracker. On a commit the gate raises a one-cycle strobe for the register that changed and presents its new value.

With default parameters there are two protected registers. Register 0 lives at 0x10, takes first key 0x01 at 0x11 and second key 0xF4 at 0x12, and resets to 0x03. Register 1 lives at 0x20, takes first key 0xAA at 0x21 and second key 0x55 at 0x22, and resets to 0x00.

Top module: `kgate_top`

## Requirements
- R1: While and after reset, `commit_o` is all zero and `value_o` holds each register's reset value (register 0 = 0x03 in bits 7:0, register 1 = 0x00 in bits 15:8).
- R2: Register 0 commits after the writes 0x11←0x01, 0x10←D, 0x12←0xF4. In the cycle after the clock edge that samples the closing key, `commit_o[0]` is 1 and `value_o[7:0]` equals D.
- R3: Register 1 commits after the writes 0x21←0xAA, 0x20←D, 0x22←0x55. In the cycle after the closing key, `commit_o[1]` is 1 and `value_o[15:8]` equals D.
- R4: A write to a protected address that no correct first key directly precedes leaves the committed value unchanged, and no later second key commits it.
- R5: A first-key write with the wrong value does not arm the tracker, so the data and key writes that follow it commit nothing.
- R6: A second-key write with the wrong value aborts the sequence, and a correct second key written after that commits nothing.
- R7: Any other bus write between the first key and the data write aborts the sequence.
- R8: Any other bus write between the data write and the second key aborts the sequence and discards the shadow value.
- R9: The keys of one register never unlock another. A correct first key for register 0 followed by a write to register 1's address commits nothing, and at most one commit bit is high in any cycle.
- R10: Cycles with `bus_we` low between the steps of a sequence neither advance nor abort it.
- R11: A correct first-key write arms the tracker from any state, so a repeated first key followed by data and second key still commits.
- R12: Each commit strobe lasts exactly one cycle, and a committed value changes only in a cycle where its strobe is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe; one write per high cycle |
| bus_addr | input | 8 | Write address |
| bus_wdata | input | 8 | Write data |
| commit_o | output | 2 | One-cycle commit strobe, one bit per protected register |
| value_o | output | 16 | Committed values, register i in bits 8i+7:8i |

## Verification
The bench targets stray writes at each of the two gaps in the sequence. A design that checks only the key values and not adjacency would commit after an unrelated write in either gap. Wrong-value keys at both ends are also tested: a gate that compares addresses only would accept them, and one that keeps its state after a bad closing key would commit on a later retry. Cross-register attempts and repeated first keys catch trackers that share state or that do not re-arm. Idle gaps inside a sequence catch a design that counts clock cycles instead of bus writes.

// File: rtl/kg_pkg.sv
package kg_pkg;
   typedef enum logic [1:0] {
      TRK_IDLE  = 2'd0,
      TRK_ARMED = 2'd1,
      TRK_HELD  = 2'd2
   } trk_state_e;
endpackage

// File: rtl/kg_tracker.sv
module kg_tracker
   import kg_pkg::*;
#(
   parameter int             AW      = 8,
   parameter int             DW      = 8,
   parameter logic [AW-1:0]  P_ADDR  = '0,
   parameter logic [AW-1:0]  K1_ADDR = '0,
   parameter logic [AW-1:0]  K2_ADDR = '0,
   parameter logic [DW-1:0]  K1_VAL  = '0,
   parameter logic [DW-1:0]  K2_VAL  = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic          commit_req,
   output logic [DW-1:0] shadow_q
);
   trk_state_e state_q, state_d;
   logic [DW-1:0] shadow_d;
   logic k1_ok, k2_ok, p_hit;

   assign k1_ok = we && (addr == K1_ADDR) && (wdata == K1_VAL);
   assign k2_ok = we && (addr == K2_ADDR) && (wdata == K2_VAL);
   assign p_hit = we && (addr == P_ADDR);

   always_comb begin
      state_d    = state_q;
      shadow_d   = shadow_q;
      commit_req = 1'b0;
      if (we) begin
         if (k1_ok) begin
            state_d  = TRK_ARMED;
            shadow_d = '0;
         end else if (state_q == TRK_ARMED && p_hit) begin
            state_d  = TRK_HELD;
            shadow_d = wdata;
         end else if (state_q == TRK_HELD && k2_ok) begin
            state_d    = TRK_IDLE;
            commit_req = 1'b1;
         end else begin
            state_d  = TRK_IDLE;
            shadow_d = '0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= TRK_IDLE;
         shadow_q <= '0;
      end else begin
         state_q  <= state_d;
         shadow_q <= shadow_d;
      end
   end

   AST_HELD_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TRK_HELD) |-> ($past(p_hit) || ($past(state_q == TRK_HELD) && !$past(we))))
      else $error("held state entered without a data write"); // R8

   AST_ARMED_NEEDS_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == TRK_ARMED) |-> ($past(k1_ok) || ($past(state_q == TRK_ARMED) && !$past(we))))
      else $error("armed state entered without first key"); // R5

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!we) |=> $stable(state_q))
      else $error("tracker moved on an idle cycle"); // R10
endmodule

// File: rtl/kg_hold.sv
module kg_hold #(
   parameter int            DW      = 8,
   parameter logic [DW-1:0] RST_VAL = '0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          commit_req,
   input  logic [DW-1:0] shadow,
   output logic          commit_o,
   output logic [DW-1:0] value_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         commit_o <= 1'b0;
         value_o  <= RST_VAL;
      end else begin
         commit_o <= commit_req;
         if (commit_req) value_o <= shadow;
      end
   end

   AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      commit_o |=> !commit_o)
      else $error("commit strobe longer than one cycle"); // R12

   AST_VALUE_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(value_o) |-> commit_o)
      else $error("value changed without commit"); // R4
endmodule

// File: rtl/kgate_top.sv
module kgate_top #(
   parameter int ADDR_W   = 8,
   parameter int DATA_W   = 8,
   parameter int NUM_PROT = 2,
   parameter logic [NUM_PROT*ADDR_W-1:0] PROT_ADDRS = {8'h20, 8'h10},
   parameter logic [NUM_PROT*ADDR_W-1:0] KEY1_ADDRS = {8'h21, 8'h11},
   parameter logic [NUM_PROT*ADDR_W-1:0] KEY2_ADDRS = {8'h22, 8'h12},
   parameter logic [NUM_PROT*DATA_W-1:0] KEY1_VALS  = {8'hAA, 8'h01},
   parameter logic [NUM_PROT*DATA_W-1:0] KEY2_VALS  = {8'h55, 8'hF4},
   parameter logic [NUM_PROT*DATA_W-1:0] RST_VALS   = {8'h00, 8'h03}
)(
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bus_we,
   input  logic [ADDR_W-1:0]          bus_addr,
   input  logic [DATA_W-1:0]          bus_wdata,
   output logic [NUM_PROT-1:0]        commit_o,
   output logic [NUM_PROT*DATA_W-1:0] value_o
);
   localparam int VAL_BITS = NUM_PROT * DATA_W;

   if (ADDR_W < 2)   $error("ADDR_W too small");
   if (DATA_W < 1)   $error("DATA_W must be positive");
   if (NUM_PROT < 1) $error("NUM_PROT must be positive");

   logic [NUM_PROT-1:0] req;
   logic [VAL_BITS-1:0] shadow;

   for (genvar g = 0; g < NUM_PROT; g++) begin : g_prot
      localparam logic [ADDR_W-1:0] PA = PROT_ADDRS[g*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] K1 = KEY1_ADDRS[g*ADDR_W +: ADDR_W];
      localparam logic [ADDR_W-1:0] K2 = KEY2_ADDRS[g*ADDR_W +: ADDR_W];

      if (PA == K1 || PA == K2 || K1 == K2) $error("key and data addresses must differ");
      for (genvar h = g + 1; h < NUM_PROT; h++) begin : g_uniq
         if (PROT_ADDRS[h*ADDR_W +: ADDR_W] == PA) $error("protected addresses must be unique");
      end

      kg_tracker #(
         .AW(ADDR_W), .DW(DATA_W), .P_ADDR(PA), .K1_ADDR(K1), .K2_ADDR(K2),
         .K1_VAL(KEY1_VALS[g*DATA_W +: DATA_W]), .K2_VAL(KEY2_VALS[g*DATA_W +: DATA_W])
      ) u_trk (
         .clk(clk), .rst_n(rst_n), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
         .commit_req(req[g]), .shadow_q(shadow[g*DATA_W +: DATA_W])
      );

      kg_hold #(.DW(DATA_W), .RST_VAL(RST_VALS[g*DATA_W +: DATA_W])) u_hold (
         .clk(clk), .rst_n(rst_n), .commit_req(req[g]),
         .shadow(shadow[g*DATA_W +: DATA_W]),
         .commit_o(commit_o[g]), .value_o(value_o[g*DATA_W +: DATA_W])
      );
   end

   AST_SINGLE_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(commit_o))
      else $error("more than one register committed at once"); // R9
endmodule

// File: tb/kgate_top_test.sv
module kgate_top_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [1:0]  commit_o;
   logic [15:0] value_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp0 = 8'h03;
   logic [7:0] exp1 = 8'h00;

   kgate_top uut (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .commit_o(commit_o), .value_o(value_o)
   );

   always #5 clk = ~clk;

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // entered and left at a falling edge
   task automatic wr(logic [7:0] a, logic [7:0] d);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic expect_state(string req, logic [1:0] c);
      check(req, {30'd0, commit_o}, {30'd0, c});
      check(req, {16'd0, value_o}, {16'd0, exp1, exp0});
   endtask

   task automatic t_reset;
      expect_state("R1", 2'b00);
   endtask

   task automatic t_commit0;
      wr(8'h11, 8'h01); wr(8'h10, 8'h5A); wr(8'h12, 8'hF4);
      exp0 = 8'h5A;
      expect_state("R2", 2'b01);
      idle(1);
      expect_state("R12", 2'b00);
   endtask

   task automatic t_commit1;
      wr(8'h21, 8'hAA); wr(8'h20, 8'hC3); wr(8'h22, 8'h55);
      exp1 = 8'hC3;
      expect_state("R3", 2'b10);
      idle(1);
      expect_state("R12", 2'b00);
   endtask

   task automatic t_no_key1;
      wr(8'h10, 8'h77); expect_state("R4", 2'b00);
      wr(8'h12, 8'hF4); expect_state("R4", 2'b00);
   endtask

   task automatic t_bad_key1;
      wr(8'h11, 8'h02); wr(8'h10, 8'h66); wr(8'h12, 8'hF4);
      expect_state("R5", 2'b00);
   endtask

   task automatic t_bad_key2;
      wr(8'h21, 8'hAA); wr(8'h20, 8'h11); wr(8'h22, 8'h54);
      expect_state("R6", 2'b00);
      wr(8'h22, 8'h55);
      expect_state("R6", 2'b00);
   endtask

   task automatic t_stray_gap1;
      wr(8'h11, 8'h01); wr(8'h40, 8'h00); wr(8'h10, 8'h22); wr(8'h12, 8'hF4);
      expect_state("R7", 2'b00);
   endtask

   task automatic t_stray_gap2;
      wr(8'h21, 8'hAA); wr(8'h20, 8'h33); wr(8'h41, 8'h99); wr(8'h22, 8'h55);
      expect_state("R8", 2'b00);
   endtask

   task automatic t_cross;
      wr(8'h11, 8'h01); wr(8'h20, 8'h44); wr(8'h22, 8'h55);
      expect_state("R9", 2'b00);
      wr(8'h11, 8'h01); wr(8'h20, 8'h45); wr(8'h12, 8'hF4);
      expect_state("R9", 2'b00);
   endtask

   task automatic t_idle_gaps;
      wr(8'h11, 8'h01); idle(3); wr(8'h10, 8'hE1); idle(2); wr(8'h12, 8'hF4);
      exp0 = 8'hE1;
      expect_state("R10", 2'b01);
      idle(1);
   endtask

   task automatic t_rearm;
      wr(8'h21, 8'hAA); wr(8'h21, 8'hAA); wr(8'h20, 8'h5C); wr(8'h22, 8'h55);
      exp1 = 8'h5C;
      expect_state("R11", 2'b10);
      wr(8'h11, 8'h01); wr(8'h10, 8'h19); wr(8'h11, 8'h01); wr(8'h10, 8'h1A); wr(8'h12, 8'hF4);
      exp0 = 8'h1A;
      expect_state("R11", 2'b01);
      idle(1);
   endtask

   initial begin : watchdog
      #500000;
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      idle(2);
      t_reset();
      rst_n = 1'b1;
      idle(2);
      t_reset();
      t_commit0();
      t_commit1();
      t_no_key1();
      t_bad_key1();
      t_bad_key2();
      t_stray_gap1();
      t_stray_gap2();
      t_cross();
      t_idle_gaps();
      t_rearm();
      idle(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule